// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial bus, placed in front of a small byte-wide nonvolatile store. In this design the store is modelled as ordinary registers. A system clock oversamples the bus clock and data lines. The block finds start and stop conditions on them and decodes a control byte made of a device-type nibble, three select bits and a direction bit. For writes, a one-byte word address follows the control byte.

Written bytes collect in a 16-byte page buffer. The buffer is copied into the array in one step when the stop condition arrives. A fixed-length busy window follows that copy. Reads stream out of an address counter that advances after every byte.

Two independent guards prevent writes. A write-protect pin blocks the whole array while it is high. A one-way lock, issued under its own device-type nibble, permanently shields the lower half of the array.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A falling data line while the clock line is high starts a command; a rising data line while the clock line is high ends it and returns the slave to idle. A stop that arrives in the middle of a byte discards the partial command, and nothing is committed.
- R2: The control byte is accepted only when bits 7:4 are 4'b1010 and bits 3:1 equal `dev_sel`. Bit 0 selects a read when it is 1. Any other control byte is not acknowledged, and the rest of that transaction is ignored until the next start or stop.
- R3: The slave pulls the data line low during the ninth clock of every byte it accepts. It leaves the line released during every bit that the master drives.
- R4: After a write control byte, the next byte loads the address counter and is always acknowledged.
- R5: Data bytes of a write are buffered and copied into the array together at the stop. The low 4 address bits wrap inside the 16-byte page rather than carrying into the next page.
- R6: A read returns the byte at the address counter, most significant bit first. The counter increments after each byte and wraps from 0xFF to 0x00, crossing page boundaries. The read continues while the master acknowledges.
- R7: For WR_CYCLES clocks after a commit, the slave acknowledges no control byte.
- R8: A write control byte with bits 7:4 equal to 4'b0110 and the matching select bits is acknowledged. The stop that follows it locks addresses 0x00 to 0x7F for good. After that, data bytes aimed at those addresses are not acknowledged and are not stored, while 0x80 to 0xFF stay writable. The read form of this byte is not acknowledged.
- R9: While `wr_protect` is high, every data byte of a write is not acknowledged and the array is left unchanged.
- R10: After reset the data line is released, the array reads 0xFF everywhere, and no lock is in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| dev_sel | input | 3 | Strapped select value compared against control-byte bits 3:1 |
| wr_protect | input | 1 | High blocks every write to the array |
| sda_pull | output | 1 | High drives the open-drain data line low |

## Verification
Two things meet at the same sampling edge: the end of the busy window and the acknowledge decision on a control byte. The bench provokes this in two ways. It probes with a control byte directly after a commit, while the window is still open, and it probes again after waiting longer than WR_CYCLES. In each case the acknowledge bit is judged against a model that records the commit time and compares the cycle of the probe with it. The stop condition is a second such point, because the same edge both commits the page and applies a pending lock. Lock tests follow a locking stop with a write at once, and the outcome is judged by the per-byte acknowledge.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int WORD_W = 8;
  localparam int SEL_W  = 3;
  localparam logic [3:0] MEM_TYPE  = 4'b1010;
  localparam logic [3:0] LOCK_TYPE = 4'b0110;

  typedef enum logic [2:0] {
    E_IDLE, E_RX, E_ACKW, E_ACK, E_TX, E_TXACK, E_WAIT
  } eng_state_t;

  typedef enum logic [1:0] {
    PH_CTRL, PH_ADDR, PH_DATA, PH_LOCK
  } phase_t;

  // a location refuses data when the pin guards everything or the lock guards the low half
  function automatic logic is_guarded(input logic [WORD_W-1:0] a,
                                      input logic wp, input logic locked);
    return wp | (locked & ~a[WORD_W-1]);
  endfunction

  // next write address: low page bits roll over, upper bits hold
  function automatic logic [WORD_W-1:0] page_step(input logic [WORD_W-1:0] a,
                                                  input int page_w);
    logic [WORD_W-1:0] m;
    m = WORD_W'((1 << page_w) - 1);
    return (a & ~m) | ((a + WORD_W'(1)) & m);
  endfunction
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_chain, sda_chain;
  logic scl_q, scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_prev  <= 1'b1;
      sda_prev  <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_in};
      sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_in};
      scl_prev  <= scl_q;
      sda_prev  <= sda_q;
    end
  end

  assign scl_q     = scl_chain[SYNC_STAGES-1];
  assign sda_q     = sda_chain[SYNC_STAGES-1];
  assign scl_rise  = scl_q & ~scl_prev;
  assign scl_fall  = ~scl_q & scl_prev;
  assign start_det = scl_q & scl_prev & sda_prev & ~sda_q;
  assign stop_det  = scl_q & scl_prev & ~sda_prev & sda_q;
endmodule

// File: rtl/twi_bit_engine.sv
module twi_bit_engine
  import twi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_q,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              ack_ok,
  input  logic              rd_after,
  input  logic [WORD_W-1:0] tx_byte,
  output logic              byte_done,
  output logic [WORD_W-1:0] rx_byte,
  output logic              tx_load,
  output logic              sda_pull,
  output logic              eng_idle
);
  eng_state_t        st;
  logic [2:0]        cnt;
  logic [WORD_W-2:0] shreg;
  logic [WORD_W-1:0] txsh;
  logic              ack_q, rd_q, mack_q;

  assign rx_byte   = {shreg, sda_q};
  assign byte_done = (st == E_RX) && scl_rise && (cnt == 3'd7);
  assign tx_load   = scl_fall && (((st == E_ACK) && rd_q) || ((st == E_TXACK) && mack_q));
  assign eng_idle  = (st == E_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= E_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      txsh     <= '0;
      ack_q    <= 1'b0;
      rd_q     <= 1'b0;
      mack_q   <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_det) begin
      st       <= E_RX;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      st       <= E_IDLE;
      sda_pull <= 1'b0;
    end else begin
      unique case (st)
        E_RX: if (scl_rise) begin
          shreg <= rx_byte[WORD_W-2:0];
          if (cnt == 3'd7) begin
            st    <= E_ACKW;
            ack_q <= ack_ok;
            rd_q  <= ack_ok & rd_after;
          end else begin
            cnt <= cnt + 3'd1;
          end
        end
        E_ACKW: if (scl_fall) begin
          if (ack_q) begin
            sda_pull <= 1'b1;
            st       <= E_ACK;
          end else begin
            st <= E_WAIT;
          end
        end
        E_ACK: if (scl_fall) begin
          cnt <= '0;
          if (rd_q) begin
            txsh     <= tx_byte;
            sda_pull <= ~tx_byte[WORD_W-1];
            st       <= E_TX;
          end else begin
            sda_pull <= 1'b0;
            st       <= E_RX;
          end
        end
        E_TX: if (scl_fall) begin
          if (cnt == 3'd7) begin
            sda_pull <= 1'b0;
            st       <= E_TXACK;
          end else begin
            cnt      <= cnt + 3'd1;
            txsh     <= {txsh[WORD_W-2:0], 1'b0};
            sda_pull <= ~txsh[WORD_W-2];
          end
        end
        E_TXACK: begin
          if (scl_rise) mack_q <= ~sda_q;
          if (scl_fall) begin
            if (mack_q) begin
              txsh     <= tx_byte;
              sda_pull <= ~tx_byte[WORD_W-1];
              cnt      <= '0;
              st       <= E_TX;
            end else begin
              st <= E_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/twi_nv_array.sv
module twi_nv_array
  import twi_pkg::*;
#(
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              buf_open,
  input  logic              buf_wr,
  input  logic [WORD_W-1:0] buf_addr,
  input  logic [WORD_W-1:0] buf_data,
  input  logic              commit_req,
  input  logic              wp,
  input  logic              lock_req,
  output logic              busy,
  output logic              locked
);
  localparam int DEPTH    = 1 << WORD_W;
  localparam int PAGE_LEN = 1 << PAGE_W;
  localparam int HI_W     = WORD_W - PAGE_W;
  localparam int CNT_W    = $clog2(WR_CYCLES + 1);

  logic [WORD_W-1:0] mem   [DEPTH];
  logic [WORD_W-1:0] pbuf  [PAGE_LEN];
  logic [PAGE_LEN-1:0] valid;
  logic [HI_W-1:0]   page_hi;
  logic [CNT_W-1:0]  busy_cnt;
  logic              do_commit;

  assign do_commit = commit_req & (|valid) & ~wp & ~busy;
  assign busy      = (busy_cnt != '0);
  assign rd_data   = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= '0;
      page_hi  <= '0;
      busy_cnt <= '0;
      locked   <= 1'b0;
    end else begin
      if (lock_req) locked <= 1'b1;
      if (do_commit) busy_cnt <= CNT_W'(WR_CYCLES);
      else if (busy) busy_cnt <= busy_cnt - CNT_W'(1);
      if (buf_open || commit_req) begin
        valid <= '0;
      end else if (buf_wr) begin
        valid[buf_addr[PAGE_W-1:0]] <= 1'b1;
        page_hi <= buf_addr[WORD_W-1:PAGE_W];
      end
    end
  end

  generate
    for (genvar p = 0; p < PAGE_LEN; p++) begin : g_pbuf
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pbuf[p] <= '0;
        else if (buf_wr && (buf_addr[PAGE_W-1:0] == PAGE_W'(p))) pbuf[p] <= buf_data;
      end
    end
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      localparam logic [WORD_W-1:0] IA = WORD_W'(i);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem[i] <= '1;
        else if (do_commit && (page_hi == IA[WORD_W-1:PAGE_W]) && valid[IA[PAGE_W-1:0]])
          mem[i] <= pbuf[IA[PAGE_W-1:0]];
      end
    end
  endgenerate
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twi_pkg::*;
#(
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int WR_CYCLES   = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [SEL_W-1:0] dev_sel,
  input  logic             wr_protect,
  output logic             sda_pull
);
  logic              sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic              byte_done, tx_load, eng_idle, ack_ok, rd_after;
  logic [WORD_W-1:0] rx_byte, rd_data, addr;
  logic              busy, locked, lock_arm;
  logic              dev_hit, lk_hit, buf_wr, buf_open, lock_req;
  phase_t            phase;

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_bit_engine u_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_q(sda_q), .start_det(start_det), .stop_det(stop_det),
    .ack_ok(ack_ok), .rd_after(rd_after), .tx_byte(rd_data),
    .byte_done(byte_done), .rx_byte(rx_byte), .tx_load(tx_load),
    .sda_pull(sda_pull), .eng_idle(eng_idle)
  );

  twi_nv_array #(.PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_arr (
    .clk(clk), .rst_n(rst_n), .rd_addr(addr), .rd_data(rd_data),
    .buf_open(buf_open), .buf_wr(buf_wr), .buf_addr(addr), .buf_data(rx_byte),
    .commit_req(stop_det), .wp(wr_protect), .lock_req(lock_req),
    .busy(busy), .locked(locked)
  );

  assign dev_hit = (rx_byte[7:4] == MEM_TYPE) && (rx_byte[3:1] == dev_sel);
  assign lk_hit  = (rx_byte[7:4] == LOCK_TYPE) && (rx_byte[3:1] == dev_sel) && !rx_byte[0];

  always_comb begin
    ack_ok   = 1'b0;
    rd_after = 1'b0;
    unique case (phase)
      PH_CTRL: begin
        ack_ok   = !busy && (dev_hit || lk_hit);
        rd_after = dev_hit && rx_byte[0];
      end
      PH_ADDR: ack_ok = 1'b1;
      PH_DATA: ack_ok = !is_guarded(addr, wr_protect, locked);
      default: ack_ok = 1'b0;
    endcase
  end

  assign buf_wr   = byte_done && ack_ok && (phase == PH_DATA);
  assign buf_open = byte_done && ack_ok && (phase == PH_CTRL) && dev_hit && !rx_byte[0];
  assign lock_req = stop_det && lock_arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CTRL;
      addr     <= '0;
      lock_arm <= 1'b0;
    end else if (start_det || stop_det) begin
      phase    <= PH_CTRL;
      lock_arm <= 1'b0;
    end else begin
      if (tx_load) addr <= addr + WORD_W'(1);
      if (byte_done && ack_ok) begin
        unique case (phase)
          PH_CTRL: begin
            if (lk_hit) begin
              phase    <= PH_LOCK;
              lock_arm <= 1'b1;
            end else if (!rx_byte[0]) begin
              phase <= PH_ADDR;
            end
          end
          PH_ADDR: begin
            addr  <= rx_byte;
            phase <= PH_DATA;
          end
          PH_DATA: addr <= page_step(addr, PAGE_W);
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_eeprom_checker.sv
module twi_eeprom_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wp,
  input logic       sda_pull,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input logic       busy,
  input logic       locked,
  input logic       buf_wr,
  input logic [7:0] buf_addr,
  input logic       eng_idle
);
  // R3: the slave only moves the data line after a falling bus clock or a bus condition
  a_r3_pull_moves_on_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> $past(scl_fall || start_det || stop_det));

  // R1: a stop returns the bit engine to idle
  a_r1_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> eng_idle);

  // R7: the busy window opens only from a stop, and nothing is buffered during it
  a_r7_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));
  a_r7_no_fill_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !buf_wr);

  // R8: lock never drops and shields the low half
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> locked);
  a_r8_low_half_shielded: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && locked) |-> buf_addr[7]);

  // R9: write-protect pin stops buffering
  a_r9_pin_blocks_fill: assert property (@(posedge clk) disable iff (!rst_n)
    wp |-> !buf_wr);
endmodule

bind twi_eeprom_slave twi_eeprom_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wp(wr_protect), .sda_pull(sda_pull),
  .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
  .busy(busy), .locked(locked), .buf_wr(buf_wr), .buf_addr(addr),
  .eng_idle(eng_idle)
);

// File: tb/twi_eeprom_slave_tb.sv
module twi_eeprom_slave_tb;
  localparam int WRC = 200;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1, wp = 1'b0;
  logic sda_pull;
  logic sda_line;
  assign sda_line = sda_drv & ~sda_pull;

  twi_eeprom_slave #(.WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .dev_sel(SEL), .wr_protect(wp), .sda_pull(sda_pull)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int busy_until = 0;
  logic [7:0] model [256];
  logic mlock = 1'b0;
  logic [7:0] wdat [16];
  logic exp_known = 1'b0, exp_pull = 1'b0;
  string exp_tag = "";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // reference comparison on every clock where the model defines the data-line pull
  always @(negedge clk) if (exp_known) chk(sda_pull === exp_pull, exp_tag, {7'd0, sda_pull}, {7'd0, exp_pull});

  task automatic bus_start();
    sda_drv = 1'b0; repeat (8) @(posedge clk);
  endtask
  task automatic bus_rstart();
    scl = 1'b0; repeat (4) @(posedge clk); sda_drv = 1'b1; repeat (4) @(posedge clk);
    scl = 1'b1; repeat (8) @(posedge clk); sda_drv = 1'b0; repeat (8) @(posedge clk);
  endtask
  task automatic bus_stop();
    scl = 1'b0; repeat (4) @(posedge clk); sda_drv = 1'b0; repeat (4) @(posedge clk);
    scl = 1'b1; repeat (8) @(posedge clk); sda_drv = 1'b1; repeat (8) @(posedge clk);
  endtask
  task automatic bus_bit(input logic b, input logic ep, input string tag);
    scl = 1'b0; repeat (4) @(posedge clk); sda_drv = b; repeat (4) @(posedge clk);
    scl = 1'b1; exp_tag = tag; exp_pull = ep; exp_known = 1'b1;
    repeat (7) @(posedge clk); exp_known = 1'b0; @(posedge clk);
  endtask
  // R3: slave stays released on master bits, pulls on the ninth clock when accepting
  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    for (int i = 7; i >= 0; i--) bus_bit(b[i], 1'b0, {tag, " R3 master bit"});
    bus_bit(1'b1, exp_ack, {tag, " ack"});
  endtask
  // R6: data MSB first, master acknowledge on the ninth clock
  task automatic recv_byte(input logic [7:0] exp, input logic mack, input string tag);
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b0; repeat (4) @(posedge clk); sda_drv = 1'b1; repeat (4) @(posedge clk);
      scl = 1'b1; repeat (4) @(posedge clk); @(negedge clk); got[i] = sda_line;
      repeat (4) @(posedge clk);
    end
    chk(got === exp, {tag, " R6 read data"}, got, exp);
    bus_bit(~mack, 1'b0, {tag, " R3 master ack"});
    sda_drv = 1'b1;
  endtask

  function automatic logic model_busy();
    return cyc < busy_until;
  endfunction

  // write n bytes from wdat starting at a, model decides every acknowledge
  task automatic do_write(input logic [7:0] a, input int n, input string tag);
    logic [7:0] stage [16]; bit sv [16]; logic [7:0] pa; bit any; bit prot;
    for (int i = 0; i < 16; i++) sv[i] = 0;
    any = 0; pa = a;
    bus_start();
    if (model_busy()) begin
      send_byte({4'hA, SEL, 1'b0}, 1'b0, {tag, " R7 ctrl"});
      bus_stop(); return;
    end
    send_byte({4'hA, SEL, 1'b0}, 1'b1, {tag, " R2 ctrl"});
    send_byte(a, 1'b1, {tag, " R4 addr"});
    for (int i = 0; i < n; i++) begin
      prot = wp || (mlock && !pa[7]);
      send_byte(wdat[i], !prot, {tag, " R5/R8/R9 data"});
      if (prot) break;
      stage[pa[3:0]] = wdat[i]; sv[pa[3:0]] = 1; any = 1;
      pa = {pa[7:4], pa[3:0] + 4'd1};
    end
    bus_stop();
    if (any && !wp) begin
      for (int i = 0; i < 16; i++) if (sv[i]) model[{pa[7:4], 4'(i)}] = stage[i];
      busy_until = cyc + WRC - 5;
    end
  endtask

  task automatic do_read(input logic [7:0] a, input int n, input string tag);
    logic [7:0] pa = a;
    bus_start();
    send_byte({4'hA, SEL, 1'b0}, 1'b1, {tag, " R2 ctrl"});
    send_byte(a, 1'b1, {tag, " R4 addr"});
    bus_rstart();
    send_byte({4'hA, SEL, 1'b1}, 1'b1, {tag, " R2 read ctrl"});
    for (int i = 0; i < n; i++) begin
      recv_byte(model[pa], i != n - 1, tag);
      pa = pa + 8'd1;
    end
    bus_stop();
  endtask

  task automatic probe(input logic [7:0] ctrl, input logic exp_ack, input string tag);
    bus_start(); send_byte(ctrl, exp_ack, tag); bus_stop();
  endtask

  task automatic settle();
    repeat (WRC + 20) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(sda_pull === 1'b0, "R10 reset pull", {7'd0, sda_pull}, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);

    do_read(8'h00, 2, "R10 erased");

    wdat[0] = 8'h5A; do_write(8'h20, 1, "single");
    settle(); do_read(8'h20, 1, "R5 single readback");

    wdat[0] = 8'h11; do_write(8'h30, 1, "busy-src");
    chk(model_busy(), "R7 model busy", 8'd1, 8'd1);
    probe({4'hA, SEL, 1'b0}, 1'b0, "R7 probe during busy");
    settle();
    probe({4'hA, SEL, 1'b0}, 1'b1, "R7 probe after busy");
    do_read(8'h30, 1, "R7 readback");

    wdat[0] = 8'hC1; wdat[1] = 8'hC2; wdat[2] = 8'hC3; wdat[3] = 8'hC4;
    do_write(8'h44, 4, "page"); settle();
    do_read(8'h44, 4, "R6 sequential");

    wdat[0] = 8'hA1; wdat[1] = 8'hA2; wdat[2] = 8'hA3;
    do_write(8'h7E, 3, "wrap"); settle();
    do_read(8'h7E, 3, "R5 wrap across page");
    do_read(8'h70, 1, "R5 wrapped byte");
    chk(model[8'h70] === 8'hA3, "R5 model wrap", model[8'h70], 8'hA3);

    do_read(8'hFF, 2, "R6 counter wrap");

    probe({4'hA, 3'b010, 1'b0}, 1'b0, "R2 wrong select");
    probe({4'hB, SEL, 1'b0}, 1'b0, "R2 wrong type");

    // R1: stop in the middle of a data byte discards it
    bus_start();
    send_byte({4'hA, SEL, 1'b0}, 1'b1, "R1 ctrl");
    send_byte(8'h10, 1'b1, "R1 addr");
    for (int i = 0; i < 4; i++) bus_bit(i[1], 1'b0, "R1 partial bit");
    bus_stop();
    probe({4'hA, SEL, 1'b0}, 1'b1, "R1 no commit so not busy");
    bus_start(); bus_stop();
    do_read(8'h10, 1, "R1 untouched");

    wp = 1'b1; wdat[0] = 8'h66; do_write(8'h50, 1, "R9 pin");
    wp = 1'b0;
    probe({4'hA, SEL, 1'b0}, 1'b1, "R9 no commit");
    do_read(8'h50, 1, "R9 untouched");

    probe({4'h6, SEL, 1'b1}, 1'b0, "R8 read form refused");
    probe({4'h6, SEL, 1'b0}, 1'b1, "R8 lock cmd");
    mlock = 1'b1;
    wdat[0] = 8'h77; do_write(8'h05, 1, "R8 low half");
    wdat[0] = 8'h88; do_write(8'hA0, 1, "R8 high half"); settle();
    do_read(8'h05, 1, "R8 low unchanged");
    do_read(8'hA0, 1, "R8 high written");
    probe({4'h6, SEL, 1'b0}, 1'b1, "R8 lock again");
    wdat[0] = 8'h99; do_write(8'h06, 1, "R8 still locked");
    do_read(8'h06, 1, "R8 still unchanged");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule